// File: doc/BRIEF.md
# Index Memory Transfer Sequencer

This block moves bytes between a small register file and a byte-wide memory, with a 12-bit index register supplying the memory address. One command at a time is accepted. Some commands act on the index alone: it can be loaded with a constant, have a register added to it, or be pointed at the glyph for a hex digit in a built-in font table whose glyphs are 5 bytes each. The other commands run over several cycles. They copy registers V0..Vn out to memory, fill V0..Vn from memory, or write a register's value as three decimal digit bytes.

The surrounding core decodes its instruction stream. It presents a command code, a register selector and an immediate for one cycle while the sequencer is idle. The sequencer reads the register file through a read port. It writes the register file through a write port. It talks to memory through a request/acknowledge port that carries exactly one byte per acknowledge. A one-cycle done pulse tells the core the command is finished, and the core can then issue the next one.

Top module: `idx_xfer_seq`

## Requirements
- R1: Command code 0xA0 loads `cmd_imm` into the index. The new value is visible on `idx_out` in the cycle where `done` is high, two cycles after the command is accepted.
- R2: Command code 0x1E adds the 8-bit value of register `cmd_reg` to the index, wrapping modulo 4096.
- R3: Command code 0x29 sets the index to FONT_BASE + 5 × (Vx & 0xF), where FONT_BASE defaults to 0. `font_warn` is high together with `done` exactly when Vx exceeds 0x0F, and is low at every other time.
- R4: Command code 0x55 with selector n writes V0, V1 .. Vn, in that order, to the bytes at index, index+1 .. index+n. It makes exactly n+1 write accesses and touches no other byte.
- R5: Command code 0x65 with selector n loads V0..Vn from the bytes at index..index+n. Registers above Vn keep their values.
- R6: After a 0x55 or 0x65 command the index has advanced by n+1. Both addresses and the index wrap modulo 4096.
- R7: Command code 0x33 writes three bytes at index, index+1 and index+2 (modulo 4096): the hundreds, tens and ones digit of the register value, each as a binary value 0..9. The index is left unchanged. The digits are formed in 8 cycles before the first write, and exactly 3 write accesses are made.
- R8: A memory request stays asserted, with stable address, direction and write data, until it is acknowledged, and one byte moves per acknowledge. `done` is high for exactly one cycle, the cycle after the last acknowledge. While `done` is high, no request and no register write is active.
- R9: A command whose code is not one of the six listed is ignored. So is any command presented while another is in progress. In both cases the index is not changed, no memory access is made and no `done` pulse results.
- R10: After reset the index is 0 and `done`, `font_warn` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 8 | Command code |
| cmd_reg | input | 4 | Register selector x / last register n |
| cmd_imm | input | 12 | Constant for the set-index command |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 8 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 8 | Register file write data |
| idx_out | output | 12 | Current index value |
| done | output | 1 | One-cycle completion pulse |
| font_warn | output | 1 | Font command saw a value above 0x0F |

## Verification
The bench sweeps the block-transfer length over every n from 0 to 15 and varies memory latency. It places sentinel bytes on both sides of each range, so a design that stops one byte early or writes one byte too far corrupts a sentinel or leaves a register unloaded. Runs that start just below 0xFFF catch an index or digit address that fails to wrap modulo 4096. The decimal command is swept over all 256 register values, which exposes a missing add-3 correction or a digit written in the wrong order. The font command is checked for all sixteen digits and for out-of-range values, where the warning must appear and the upper nibble must be dropped. Unknown codes and a command issued in the middle of a transfer are checked for side effects on the index, on memory traffic and on `done`.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

   // Command codes seen on cmd_code
   localparam logic [7:0] OPC_SETIDX  = 8'hA0;
   localparam logic [7:0] OPC_ADDIDX  = 8'h1E;
   localparam logic [7:0] OPC_GLYPH   = 8'h29;
   localparam logic [7:0] OPC_DECIMAL = 8'h33;
   localparam logic [7:0] OPC_SAVE    = 8'h55;
   localparam logic [7:0] OPC_FETCH   = 8'h65;

   typedef enum logic [2:0] {
      OP_SETIDX, OP_ADDIDX, OP_GLYPH, OP_DECIMAL, OP_SAVE, OP_FETCH
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SETUP, ST_SAVE, ST_FETCH, ST_CONV, ST_EMIT, ST_FIN
   } state_e;

   typedef enum logic [2:0] {
      IX_HOLD, IX_LOAD, IX_ADD, IX_GLYPH, IX_STEP
   } ixctl_e;

   // Number of decimal digits needed for an unsigned value of w bits
   function automatic int dec_digits(input int w);
      longint unsigned v;
      int d;
      v = (64'd1 << w) - 64'd1;
      d = 0;
      while (v != 0) begin
         v = v / 10;
         d++;
      end
      if (d == 0) d = 1;
      return d;
   endfunction

endpackage

// File: rtl/ixs_bcd_conv.sv
module ixs_bcd_conv
   import ixs_pkg::*;
#(
   parameter int BIN_W  = 8,
   parameter int DIGITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [BIN_W-1:0]    bin_in,
   output logic                busy,
   output logic [4*DIGITS-1:0] digits
);

   localparam int CNT_W = $clog2(BIN_W + 1);

   if (DIGITS < dec_digits(BIN_W)) begin : g_bad_digits
      $error("ixs_bcd_conv: DIGITS too small for BIN_W");
   end

   logic [BIN_W-1:0]    bin_q;
   logic [4*DIGITS-1:0] bcd_q;
   logic [4*DIGITS-1:0] adj;
   logic [CNT_W-1:0]    left_q;

   // add-3 correction on each digit before the shift
   for (genvar g = 0; g < DIGITS; g++) begin : g_adj
      assign adj[4*g +: 4] = (bcd_q[4*g +: 4] >= 4'd5) ? bcd_q[4*g +: 4] + 4'd3
                                                       : bcd_q[4*g +: 4];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         bcd_q  <= '0;
         left_q <= '0;
      end else if (start) begin
         bin_q  <= bin_in;
         bcd_q  <= '0;
         left_q <= CNT_W'(BIN_W);
      end else if (left_q != '0) begin
         bcd_q  <= {adj[4*DIGITS-2:0], bin_q[BIN_W-1]};
         bin_q  <= bin_q << 1;
         left_q <= left_q - 1'b1;
      end
   end

   assign busy   = (left_q != '0);
   assign digits = bcd_q;

endmodule

// File: rtl/ixs_index_reg.sv
module ixs_index_reg
   import ixs_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 8,
   parameter int GLYPH_BYTES = 5,
   parameter int FONT_BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ixctl_e            ctl,
   input  logic [ADDR_W-1:0] imm,
   input  logic [DATA_W-1:0] opnd,
   output logic [ADDR_W-1:0] idx
);

   localparam bit GLYPH_POW2 = ((GLYPH_BYTES & (GLYPH_BYTES - 1)) == 0);
   localparam int GLYPH_SH   = $clog2(GLYPH_BYTES);

   logic [ADDR_W-1:0] idx_q;
   logic [ADDR_W-1:0] glyph_off;

   if (GLYPH_POW2) begin : g_shift
      assign glyph_off = ADDR_W'(opnd[3:0]) << GLYPH_SH;
   end else begin : g_mul
      assign glyph_off = ADDR_W'(opnd[3:0]) * ADDR_W'(GLYPH_BYTES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else begin
         case (ctl)
            IX_LOAD:  idx_q <= imm;
            IX_ADD:   idx_q <= idx_q + ADDR_W'(opnd);
            IX_GLYPH: idx_q <= ADDR_W'(FONT_BASE) + glyph_off;
            IX_STEP:  idx_q <= idx_q + 1'b1;
            default:  idx_q <= idx_q;
         endcase
      end
   end

   assign idx = idx_q;

endmodule

// File: rtl/idx_xfer_seq.sv
module idx_xfer_seq
   import ixs_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 8,
   parameter int REG_CNT     = 16,
   parameter int GLYPH_BYTES = 5,
   parameter int FONT_BASE   = 0,
   localparam int RSEL_W     = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic [RSEL_W-1:0] cmd_reg,
   input  logic [ADDR_W-1:0] cmd_imm,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [RSEL_W-1:0] rf_raddr,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              rf_we,
   output logic [RSEL_W-1:0] rf_waddr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic [ADDR_W-1:0] idx_out,
   output logic              done,
   output logic              font_warn
);

   localparam int DIGITS = dec_digits(DATA_W);
   localparam int DSEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
   localparam int CNT_W  = (RSEL_W > DSEL_W) ? RSEL_W : DSEL_W;

   // elaboration-time parameter checks
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("idx_xfer_seq: ADDR_W out of range");
   end
   if (DATA_W < 5) begin : g_bad_data
      $error("idx_xfer_seq: DATA_W must hold values above 0x0F");
   end
   if (REG_CNT < 2) begin : g_bad_regs
      $error("idx_xfer_seq: REG_CNT must be at least 2");
   end
   if (GLYPH_BYTES < 1) begin : g_bad_glyph
      $error("idx_xfer_seq: GLYPH_BYTES must be positive");
   end
   if (FONT_BASE < 0 || FONT_BASE >= (1 << ADDR_W)) begin : g_bad_base
      $error("idx_xfer_seq: FONT_BASE outside address space");
   end

   state_e              state_q, state_d;
   op_e                 op_q, cmd_op;
   logic                cmd_known;
   logic [RSEL_W-1:0]   reg_q;
   logic [ADDR_W-1:0]   imm_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                cnt_inc;
   logic                warn_q;
   logic                last_reg;
   logic                last_digit;
   ixctl_e              ixctl;
   logic [ADDR_W-1:0]   idx;
   logic                bcd_start;
   logic                bcd_busy;
   logic [4*DIGITS-1:0] bcd_digits;
   logic [3:0]          digit_sel;

   // command code decode
   always_comb begin
      cmd_known = 1'b1;
      cmd_op    = OP_SETIDX;
      case (cmd_code)
         OPC_SETIDX:  cmd_op = OP_SETIDX;
         OPC_ADDIDX:  cmd_op = OP_ADDIDX;
         OPC_GLYPH:   cmd_op = OP_GLYPH;
         OPC_DECIMAL: cmd_op = OP_DECIMAL;
         OPC_SAVE:    cmd_op = OP_SAVE;
         OPC_FETCH:   cmd_op = OP_FETCH;
         default:     cmd_known = 1'b0;
      endcase
   end

   assign last_reg   = (cnt_q == CNT_W'(reg_q));
   assign last_digit = (cnt_q == CNT_W'(DIGITS - 1));

   // digit for the current write, most significant first
   always_comb begin
      digit_sel = '0;
      for (int k = 0; k < DIGITS; k++) begin
         if (cnt_q == CNT_W'(k)) digit_sel = bcd_digits[4*(DIGITS-1-k) +: 4];
      end
   end

   always_comb begin
      state_d   = state_q;
      ixctl     = IX_HOLD;
      rf_raddr  = reg_q;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = idx;
      mem_wdata = rf_rdata;
      rf_we     = 1'b0;
      bcd_start = 1'b0;
      cnt_inc   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (cmd_valid && cmd_known) state_d = ST_SETUP;
         end
         ST_SETUP: begin
            case (op_q)
               OP_SETIDX: begin ixctl = IX_LOAD;  state_d = ST_FIN; end
               OP_ADDIDX: begin ixctl = IX_ADD;   state_d = ST_FIN; end
               OP_GLYPH:  begin ixctl = IX_GLYPH; state_d = ST_FIN; end
               OP_DECIMAL: begin bcd_start = 1'b1; state_d = ST_CONV; end
               OP_SAVE:   state_d = ST_SAVE;
               default:   state_d = ST_FETCH;
            endcase
         end
         ST_SAVE: begin
            rf_raddr = cnt_q[RSEL_W-1:0];
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            if (mem_ack) begin
               ixctl   = IX_STEP;
               cnt_inc = 1'b1;
               if (last_reg) state_d = ST_FIN;
            end
         end
         ST_FETCH: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               rf_we   = 1'b1;
               ixctl   = IX_STEP;
               cnt_inc = 1'b1;
               if (last_reg) state_d = ST_FIN;
            end
         end
         ST_CONV: begin
            if (!bcd_busy) state_d = ST_EMIT;
         end
         ST_EMIT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = idx + ADDR_W'(cnt_q);
            mem_wdata = DATA_W'(digit_sel);
            if (mem_ack) begin
               cnt_inc = 1'b1;
               if (last_digit) state_d = ST_FIN;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_SETIDX;
         reg_q   <= '0;
         imm_q   <= '0;
         cnt_q   <= '0;
         warn_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cmd_valid && cmd_known) begin
            op_q  <= cmd_op;
            reg_q <= cmd_reg;
            imm_q <= cmd_imm;
         end
         if (state_q == ST_SETUP) begin
            cnt_q  <= '0;
            warn_q <= (op_q == OP_GLYPH) && (rf_rdata > DATA_W'(15));
         end else if (cnt_inc) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   ixs_index_reg #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .GLYPH_BYTES (GLYPH_BYTES),
      .FONT_BASE   (FONT_BASE)
   ) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ixctl),
      .imm   (imm_q),
      .opnd  (rf_rdata),
      .idx   (idx)
   );

   ixs_bcd_conv #(
      .BIN_W  (DATA_W),
      .DIGITS (DIGITS)
   ) u_bcd (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (bcd_start),
      .bin_in (rf_rdata),
      .busy   (bcd_busy),
      .digits (bcd_digits)
   );

   assign rf_waddr  = cnt_q[RSEL_W-1:0];
   assign rf_wdata  = mem_rdata;
   assign idx_out   = idx;
   assign done      = (state_q == ST_FIN);
   assign font_warn = done && warn_q;

endmodule

// File: rtl/ixs_chk.sv
module ixs_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              rf_we,
   input logic [ADDR_W-1:0] idx_out,
   input logic              done,
   input logic              font_warn
);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req && !rf_we);

   // R3
   warn_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      font_warn |-> done);

   // R6
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_we |=> idx_out == ADDR_W'($past(idx_out) + 1'b1));

   // R5
   load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> mem_req && mem_ack && !mem_we);

endmodule

bind idx_xfer_seq ixs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ixs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .rf_we     (rf_we),
   .idx_out   (idx_out),
   .done      (done),
   .font_warn (font_warn)
);

// File: tb/tb_idx_xfer_seq.sv
module tb_idx_xfer_seq;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic [3:0]  cmd_reg = '0;
   logic [11:0] cmd_imm = '0;
   logic        mem_req, mem_we;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic [3:0]  rf_raddr;
   logic [7:0]  rf_rdata;
   logic        rf_we;
   logic [3:0]  rf_waddr;
   logic [7:0]  rf_wdata;
   logic [11:0] idx_out;
   logic        done, font_warn;

   logic [7:0]  mem [4096];
   logic [7:0]  rf [16];
   int          lat = 0;
   int          nacc = 0;
   int          nchk = 0;
   int          nfail = 0;
   logic        seen_warn;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rf_rdata = rf[rf_raddr];
   always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

   idx_xfer_seq dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_reg(cmd_reg), .cmd_imm(cmd_imm), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .idx_out(idx_out), .done(done), .font_warn(font_warn)
   );

   // memory model: acknowledges after lat idle cycles, one byte per ack
   initial begin
      int wcnt;
      wcnt = 0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req && rst_n) begin
            if (wcnt >= lat) begin
               if (mem_we) mem[mem_addr] = mem_wdata;
               else        mem_rdata = mem[mem_addr];
               mem_ack = 1'b1;
               nacc++;
               wcnt = 0;
            end else begin
               wcnt++;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] code, input logic [3:0] r, input logic [11:0] imm);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = code;
      cmd_reg   = r;
      cmd_imm   = imm;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // waits for done, records font_warn, then checks the pulse ends (R8)
   task automatic wait_done(input string tag);
      bit got;
      got = 1'b0;
      seen_warn = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (done) begin
            got = 1'b1;
            seen_warn = font_warn;
            break;
         end
         @(negedge clk);
      end
      check(got, {tag, " done seen"}, got, 1);
      @(negedge clk);
      check(done == 1'b0, "R8 done single pulse", done, 0);
   endtask

   task automatic set_idx(input logic [11:0] v);
      issue(8'hA0, 4'd0, v);
      wait_done("R1");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      for (int i = 0; i < 16; i++) rf[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check(idx_out == 12'h000, "R10 idx after reset", idx_out, 0);
      check(done == 1'b0, "R10 done after reset", done, 0);
      check(font_warn == 1'b0, "R10 warn after reset", font_warn, 0);
      check(mem_req == 1'b0, "R10 req after reset", mem_req, 0);

      // R1 set index
      begin
         logic [11:0] vals [4] = '{12'h000, 12'hFFF, 12'h5A3, 12'h800};
         foreach (vals[k]) begin
            issue(8'hA0, 4'd0, vals[k]);
            for (int i = 0; i < 4 && !done; i++) @(negedge clk);
            check(idx_out == vals[k], "R1 set index", idx_out, vals[k]);
            wait_done("R1");
         end
      end

      // R2 add to index with wrap
      begin
         logic [11:0] bases [4] = '{12'h010, 12'hFF0, 12'hFFF, 12'h000};
         logic [7:0]  adds  [4] = '{8'h20, 8'h20, 8'hFF, 8'h00};
         foreach (bases[k]) begin
            set_idx(bases[k]);
            rf[3] = adds[k];
            issue(8'h1E, 4'd3, 12'h000);
            wait_done("R2");
            check(idx_out == 12'(bases[k] + adds[k]), "R2 add to index", idx_out,
                  12'(bases[k] + adds[k]));
         end
      end

      // R3 font glyph pointer, all digits and out-of-range values
      for (int d = 0; d < 16; d++) begin
         set_idx(12'h777);
         rf[5] = 8'(d);
         issue(8'h29, 4'd5, 12'h000);
         wait_done("R3");
         check(idx_out == 12'(5 * d), "R3 glyph index", idx_out, 5 * d);
         check(seen_warn == 1'b0, "R3 no warning", seen_warn, 0);
      end
      begin
         logic [7:0] bad [3] = '{8'h1A, 8'hFF, 8'h10};
         foreach (bad[k]) begin
            rf[9] = bad[k];
            issue(8'h29, 4'd9, 12'h000);
            wait_done("R3");
            check(idx_out == 12'(5 * bad[k][3:0]), "R3 glyph masked", idx_out, 5 * bad[k][3:0]);
            check(seen_warn == 1'b1, "R3 warning raised", seen_warn, 1);
            check(font_warn == 1'b0, "R3 warning ends", font_warn, 0);
         end
      end

      // R4 / R6 store-multiple sweep
      for (int n = 0; n < 16; n++) begin
         int base, a0;
         base = 12'h100 + n * 12'h020;
         lat = n % 3;
         for (int k = 0; k < 16; k++) rf[k] = 8'((k * 37 + n * 11 + 5) & 8'hFF);
         for (int a = -1; a < 18; a++) mem[12'(base + a)] = 8'hEE;
         set_idx(12'(base));
         a0 = nacc;
         issue(8'h55, 4'(n), 12'h000);
         wait_done("R4");
         for (int k = 0; k <= n; k++)
            check(mem[12'(base + k)] == rf[k], "R4 stored byte", mem[12'(base + k)], rf[k]);
         check(mem[12'(base + n + 1)] == 8'hEE, "R4 byte after range", mem[12'(base + n + 1)], 8'hEE);
         check(mem[12'(base - 1)] == 8'hEE, "R4 byte before range", mem[12'(base - 1)], 8'hEE);
         check(nacc - a0 == n + 1, "R4 access count", nacc - a0, n + 1);
         check(idx_out == 12'(base + n + 1), "R6 index after store", idx_out, base + n + 1);
      end

      // R6 store wrapping past 0xFFF
      lat = 1;
      for (int k = 0; k < 4; k++) rf[k] = 8'(8'hA0 + k);
      set_idx(12'hFFE);
      issue(8'h55, 4'd3, 12'h000);
      wait_done("R6");
      check(mem[12'hFFE] == 8'hA0, "R6 wrap byte 0", mem[12'hFFE], 8'hA0);
      check(mem[12'hFFF] == 8'hA1, "R6 wrap byte 1", mem[12'hFFF], 8'hA1);
      check(mem[12'h000] == 8'hA2, "R6 wrap byte 2", mem[12'h000], 8'hA2);
      check(mem[12'h001] == 8'hA3, "R6 wrap byte 3", mem[12'h001], 8'hA3);
      check(idx_out == 12'h002, "R6 index wraps", idx_out, 2);

      // R5 / R6 load-multiple sweep
      for (int n = 0; n < 16; n++) begin
         int base;
         base = 12'h600 + n * 12'h020;
         lat = (n + 1) % 3;
         for (int k = 0; k < 16; k++) begin
            mem[12'(base + k)] = 8'((k * 53 + n * 7 + 1) & 8'hFF);
            rf[k] = 8'h5C;
         end
         set_idx(12'(base));
         issue(8'h65, 4'(n), 12'h000);
         wait_done("R5");
         for (int k = 0; k < 16; k++) begin
            if (k <= n)
               check(rf[k] == mem[12'(base + k)], "R5 loaded register", rf[k], mem[12'(base + k)]);
            else
               check(rf[k] == 8'h5C, "R5 register above n kept", rf[k], 8'h5C);
         end
         check(idx_out == 12'(base + n + 1), "R6 index after load", idx_out, base + n + 1);
      end

      // R7 decimal digits for every byte value
      set_idx(12'h300);
      for (int v = 0; v < 256; v++) begin
         int a0;
         lat = v % 2;
         for (int a = 0; a < 4; a++) mem[12'h300 + a] = 8'hEE;
         rf[7] = 8'(v);
         a0 = nacc;
         issue(8'h33, 4'd7, 12'h000);
         wait_done("R7");
         check(mem[12'h300] == 8'(v / 100), "R7 hundreds", mem[12'h300], v / 100);
         check(mem[12'h301] == 8'((v / 10) % 10), "R7 tens", mem[12'h301], (v / 10) % 10);
         check(mem[12'h302] == 8'(v % 10), "R7 ones", mem[12'h302], v % 10);
         check(mem[12'h303] == 8'hEE, "R7 no fourth byte", mem[12'h303], 8'hEE);
         check(nacc - a0 == 3, "R7 access count", nacc - a0, 3);
         check(idx_out == 12'h300, "R7 index unchanged", idx_out, 12'h300);
      end

      // R7 digit addresses wrap
      set_idx(12'hFFF);
      rf[2] = 8'd209;
      issue(8'h33, 4'd2, 12'h000);
      wait_done("R7");
      check(mem[12'hFFF] == 8'd2, "R7 wrap hundreds", mem[12'hFFF], 2);
      check(mem[12'h000] == 8'd0, "R7 wrap tens", mem[12'h000], 0);
      check(mem[12'h001] == 8'd9, "R7 wrap ones", mem[12'h001], 9);
      check(idx_out == 12'hFFF, "R7 wrap index unchanged", idx_out, 12'hFFF);

      // R9 unknown codes ignored
      set_idx(12'h123);
      begin
         logic [7:0] junk [3] = '{8'h42, 8'h00, 8'h56};
         foreach (junk[k]) begin
            int a0;
            bit any_done;
            a0 = nacc;
            any_done = 1'b0;
            issue(junk[k], 4'd4, 12'hABC);
            for (int i = 0; i < 20; i++) begin
               if (done) any_done = 1'b1;
               @(negedge clk);
            end
            check(any_done == 1'b0, "R9 no done for unknown code", any_done, 0);
            check(nacc == a0, "R9 no access for unknown code", nacc - a0, 0);
            check(idx_out == 12'h123, "R9 index kept", idx_out, 12'h123);
         end
      end

      // R9 command during a transfer ignored
      begin
         bit any_done;
         lat = 2;
         for (int k = 0; k < 3; k++) rf[k] = 8'(8'h30 + k);
         set_idx(12'h200);
         issue(8'h55, 4'd2, 12'h000);
         issue(8'hA0, 4'd0, 12'h0AB);
         wait_done("R9");
         check(idx_out == 12'h203, "R9 busy command ignored", idx_out, 12'h203);
         check(mem[12'h202] == 8'h32, "R9 transfer intact", mem[12'h202], 8'h32);
         any_done = 1'b0;
         for (int i = 0; i < 10; i++) begin
            if (done) any_done = 1'b1;
            @(negedge clk);
         end
         check(any_done == 1'b0, "R9 no late done", any_done, 0);
         check(idx_out == 12'h203, "R9 index after idle", idx_out, 12'h203);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule